// File: doc/BRIEF.md
# Two-Phase ADC Averager with Temperature Estimate

This block turns a stream of analog-to-digital readout words into a signed temperature estimate. A start pulse launches a measurement run. The block fetches words one at a time over a request/response port. Each phase first discards a warm-up pair of valid readings and then accumulates a fixed number of valid samples. Between the two phases the block asks an external analog selector to switch its input and waits for an acknowledge.

After both phases the block scales each sum into an average (times 1000). It combines the two averages into a ratio term. It then evaluates a fixed quadratic polynomial with truncating integer arithmetic. All divisions share one multi-cycle sequential divider.

The result is presented with a one-cycle done pulse. If either phase runs out of its read budget, done comes with an error flag instead of a new result.

Top module: `thermo_avg`

## Requirements
- R1: A readout word marks a usable reading with bit 10 set and carries the sample value in bits [9:0]. A word with bit 10 clear is skipped: its sample bits never reach a sum and it does not count toward any sample total.
- R2: At the start of each phase, the first DISCARD (default 2) valid readings are dropped before accumulation begins.
- R3: In the warm-up part of a phase, if the read count exceeds DISC_BUDGET without DISCARD valid readings, the run ends with done and err both high, after exactly DISC_BUDGET+1 reads in that phase.
- R4: Each phase sums exactly NSAMP (default 80) valid samples, and its average is m = (sum × 1000) / NSAMP, truncated.
- R5: In the accumulation part of a phase, if the read count exceeds ACC_BUDGET before NSAMP valid samples arrive, the run ends with done and err both high, after exactly ACC_BUDGET+1 reads in that part.
- R6: rd_req is a one-cycle pulse. At most one read is outstanding. The next request is issued only after the response to the previous one.
- R7: After phase one, sel_req rises and stays high until sel_ack is seen. No read is requested while sel_req is high, and phase-two reads start only after the acknowledge.
- R8: If m2 / 1000 is zero, m2 is replaced by 1000 before the ratio term is formed.
- R9: The result is temp = (((−559·a)/1000)·a)/1000 + (1379·a)/1000 − 458, where a = (m2 − m1)/(m2/1000). Every division truncates toward zero in the order written.
- R10: done is a single-cycle pulse, err is high only together with done, and temp changes only in the cycle done is high. A failed run leaves temp at its previous value.
- R11: A start pulse that arrives while a run is in progress is ignored.
- R12: During and right after reset, rd_req, sel_req, done and err are low and temp is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a measurement run when idle |
| rd_req | output | 1 | One-cycle read request |
| rsp_vld | input | 1 | Response strobe for the outstanding read |
| rsp_word | input | SAMP_W+1 | Readout word: valid flag in the top bit, sample below it |
| sel_req | output | 1 | Asks the analog selector to switch to the second measurement |
| sel_ack | input | 1 | Selector has switched |
| done | output | 1 | Run finished (result or error) |
| err | output | 1 | Run aborted on a read budget, valid with done |
| temp | output | MATH_W | Signed temperature estimate |

## Verification
The bench builds the block with DISC_BUDGET = 12 and ACC_BUDGET = 150. Both abort paths can then be reached in a few hundred cycles, and the exact read counts at the point of abort can be compared against budget plus one. NSAMP, DISCARD and MATH_W keep their defaults, so the polynomial and the warm-up drop are exercised exactly as specified. Directed sample levels drive the m2 floor and the extreme values of the ratio term, including a large negative one.

// File: rtl/tavg_pkg.sv
package tavg_pkg;
  localparam int SCALE  = 1000;
  localparam int K_QUAD = 559;
  localparam int K_LIN  = 1379;
  localparam int K_OFS  = 458;

  typedef enum logic [2:0] {
    T_IDLE,
    T_PH1,
    T_SEL,
    T_PH2,
    T_MATH
  } top_state_t;

  typedef enum logic [1:0] {
    M_IDLE,
    M_ISSUE,
    M_WAIT,
    M_FIN
  } math_state_t;
endpackage

// File: rtl/tavg_sdiv.sv
// Sequential restoring divider: signed numerator, positive divisor,
// quotient truncated toward zero. W cycles per operation.
module tavg_sdiv #(
  parameter int W = 48
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic signed [W-1:0] num,
  input  logic        [W-1:0] den,
  output logic                done,
  output logic signed [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W-1:0]  q;
  logic [CW-1:0] cnt;
  logic          neg;
  logic          busy;
  logic [W:0]    sh;

  assign sh = {rem[W-1:0], q[W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      q    <= '0;
      cnt  <= '0;
      neg  <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
      quo  <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        neg  <= num[W-1];
        q    <= num[W-1] ? $unsigned(-num) : $unsigned(num);
        rem  <= '0;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          quo  <= neg ? -$signed(q) : $signed(q);
        end else begin
          cnt <= cnt - 1'b1;
          if (sh >= {1'b0, den}) begin
            rem <= sh - {1'b0, den};
            q   <= {q[W-2:0], 1'b1};
          end else begin
            rem <= sh;
            q   <= {q[W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/tavg_accum.sv
// One measurement phase: request reads, drop warm-up valids, sum samples.
module tavg_accum #(
  parameter int SAMP_W      = 10,
  parameter int NSAMP       = 80,
  parameter int DISCARD     = 2,
  parameter int DISC_BUDGET = 100000,
  parameter int ACC_BUDGET  = 1000000,
  parameter int SUM_W       = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              rsp_vld,
  input  logic [SAMP_W:0]   rsp_word,
  output logic              rd_req,
  output logic              fin,
  output logic              fail,
  output logic [SUM_W-1:0]  sum
);
  localparam int MAXB = (DISC_BUDGET > ACC_BUDGET) ? DISC_BUDGET : ACC_BUDGET;
  localparam int CW   = $clog2(MAXB + 2);
  localparam int NW   = $clog2(NSAMP + 1);
  localparam int DW   = $clog2(DISCARD + 2);

  logic              busy;
  logic              in_warm;
  logic [DW-1:0]     dcnt;
  logic [NW-1:0]     vcnt;
  logic [CW-1:0]     rcnt;
  logic [CW-1:0]     rcnt_nx;
  logic              vld;
  logic [SAMP_W-1:0] samp;

  assign vld     = rsp_word[SAMP_W];
  assign samp    = rsp_word[SAMP_W-1:0];
  assign rcnt_nx = rcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      in_warm <= 1'b0;
      dcnt    <= '0;
      vcnt    <= '0;
      rcnt    <= '0;
      sum     <= '0;
      rd_req  <= 1'b0;
      fin     <= 1'b0;
      fail    <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      fin    <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy    <= 1'b1;
          rd_req  <= 1'b1;
          in_warm <= (DISCARD != 0);
          dcnt    <= '0;
          vcnt    <= '0;
          rcnt    <= '0;
          sum     <= '0;
          fail    <= 1'b0;
        end
      end else if (rsp_vld) begin
        if (in_warm) begin
          if (vld && dcnt == DW'(DISCARD - 1)) begin
            in_warm <= 1'b0;
            rcnt    <= '0;
            rd_req  <= 1'b1;
          end else if (rcnt_nx > CW'(DISC_BUDGET)) begin
            busy <= 1'b0;
            fin  <= 1'b1;
            fail <= 1'b1;
          end else begin
            if (vld) dcnt <= dcnt + 1'b1;
            rcnt   <= rcnt_nx;
            rd_req <= 1'b1;
          end
        end else begin
          if (vld && vcnt == NW'(NSAMP - 1)) begin
            sum  <= sum + SUM_W'(samp);
            busy <= 1'b0;
            fin  <= 1'b1;
            fail <= 1'b0;
          end else if (rcnt_nx > CW'(ACC_BUDGET)) begin
            busy <= 1'b0;
            fin  <= 1'b1;
            fail <= 1'b1;
          end else begin
            if (vld) begin
              sum  <= sum + SUM_W'(samp);
              vcnt <= vcnt + 1'b1;
            end
            rcnt   <= rcnt_nx;
            rd_req <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tavg_math.sv
// Averages and polynomial, all divisions through one sequential divider.
module tavg_math
  import tavg_pkg::*;
#(
  parameter int NSAMP = 80,
  parameter int SUM_W = 17,
  parameter int MW    = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic [SUM_W-1:0]     sum_a,
  input  logic [SUM_W-1:0]     sum_b,
  output logic                 done,
  output logic signed [MW-1:0] result
);
  localparam logic signed [MW-1:0] KS = MW'(SCALE);
  localparam logic signed [MW-1:0] KQ = MW'(K_QUAD);
  localparam logic signed [MW-1:0] KL = MW'(K_LIN);
  localparam logic signed [MW-1:0] KO = MW'(K_OFS);
  localparam logic        [MW-1:0] KN = MW'(NSAMP);
  localparam logic        [2:0]    LAST_OP = 3'd6;

  math_state_t st;
  logic [2:0]  op;
  logic signed [MW-1:0] m1, m2, k, a, t1, t2, t3;
  logic signed [MW-1:0] num;
  logic        [MW-1:0] den;
  logic                 div_go;
  logic                 div_done;
  logic signed [MW-1:0] q;

  always_comb begin
    num = '0;
    den = $unsigned(KS);
    case (op)
      3'd0: begin num = $signed(MW'(sum_a)) * KS; den = KN; end
      3'd1: begin num = $signed(MW'(sum_b)) * KS; den = KN; end
      3'd2: num = m2;
      3'd3: begin num = m2 - m1; den = $unsigned(k); end
      3'd4: num = -(KQ * a);
      3'd5: num = t1 * a;
      default: num = KL * a;
    endcase
  end

  tavg_sdiv #(.W(MW)) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  (num),
    .den  (den),
    .done (div_done),
    .quo  (q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= M_IDLE;
      op     <= '0;
      div_go <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      m1 <= '0; m2 <= '0; k <= '0; a <= '0;
      t1 <= '0; t2 <= '0; t3 <= '0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      case (st)
        M_IDLE: if (go) begin
          op <= '0;
          st <= M_ISSUE;
        end
        M_ISSUE: begin
          div_go <= 1'b1;
          st     <= M_WAIT;
        end
        M_WAIT: if (div_done) begin
          case (op)
            3'd0: m1 <= q;
            3'd1: m2 <= q;
            3'd2: if (q == '0) begin
              m2 <= KS;
              k  <= MW'(1);
            end else begin
              k <= q;
            end
            3'd3: a  <= q;
            3'd4: t1 <= q;
            3'd5: t2 <= q;
            default: t3 <= q;
          endcase
          if (op == LAST_OP) begin
            st <= M_FIN;
          end else begin
            op <= op + 1'b1;
            st <= M_ISSUE;
          end
        end
        default: begin
          result <= t2 + t3 - KO;
          done   <= 1'b1;
          st     <= M_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/thermo_avg.sv
module thermo_avg
  import tavg_pkg::*;
#(
  parameter int SAMP_W      = 10,
  parameter int NSAMP       = 80,
  parameter int DISCARD     = 2,
  parameter int DISC_BUDGET = 100000,
  parameter int ACC_BUDGET  = 1000000,
  parameter int MATH_W      = 48
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     rd_req,
  input  logic                     rsp_vld,
  input  logic [SAMP_W:0]          rsp_word,
  output logic                     sel_req,
  input  logic                     sel_ack,
  output logic                     done,
  output logic                     err,
  output logic signed [MATH_W-1:0] temp
);
  localparam int SUM_W = SAMP_W + $clog2(NSAMP + 1);

  top_state_t st;
  logic              acc_go;
  logic              acc_fin;
  logic              acc_fail;
  logic [SUM_W-1:0]  acc_sum;
  logic [SUM_W-1:0]  sum1;
  logic [SUM_W-1:0]  sum2;
  logic              math_go;
  logic              math_done;
  logic signed [MATH_W-1:0] math_res;

  tavg_accum #(
    .SAMP_W(SAMP_W), .NSAMP(NSAMP), .DISCARD(DISCARD),
    .DISC_BUDGET(DISC_BUDGET), .ACC_BUDGET(ACC_BUDGET), .SUM_W(SUM_W)
  ) u_accum (
    .clk(clk), .rst(rst), .go(acc_go), .rsp_vld(rsp_vld), .rsp_word(rsp_word),
    .rd_req(rd_req), .fin(acc_fin), .fail(acc_fail), .sum(acc_sum)
  );

  tavg_math #(.NSAMP(NSAMP), .SUM_W(SUM_W), .MW(MATH_W)) u_math (
    .clk(clk), .rst(rst), .go(math_go), .sum_a(sum1), .sum_b(sum2),
    .done(math_done), .result(math_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= T_IDLE;
      acc_go  <= 1'b0;
      math_go <= 1'b0;
      sel_req <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      temp    <= '0;
      sum1    <= '0;
      sum2    <= '0;
    end else begin
      acc_go  <= 1'b0;
      math_go <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      case (st)
        T_IDLE: if (start) begin
          acc_go <= 1'b1;
          st     <= T_PH1;
        end
        T_PH1: if (acc_fin) begin
          if (acc_fail) begin
            done <= 1'b1;
            err  <= 1'b1;
            st   <= T_IDLE;
          end else begin
            sum1    <= acc_sum;
            sel_req <= 1'b1;
            st      <= T_SEL;
          end
        end
        T_SEL: if (sel_ack) begin
          sel_req <= 1'b0;
          acc_go  <= 1'b1;
          st      <= T_PH2;
        end
        T_PH2: if (acc_fin) begin
          if (acc_fail) begin
            done <= 1'b1;
            err  <= 1'b1;
            st   <= T_IDLE;
          end else begin
            sum2    <= acc_sum;
            math_go <= 1'b1;
            st      <= T_MATH;
          end
        end
        default: if (math_done) begin
          temp <= math_res;
          done <= 1'b1;
          st   <= T_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/thermo_avg_chk.sv
module thermo_avg_chk #(
  parameter int MW = 48
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_req,
  input logic                 sel_req,
  input logic                 sel_ack,
  input logic                 done,
  input logic                 err,
  input logic signed [MW-1:0] temp
);
  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  assert_no_read_switch_R7: assert property (@(posedge clk) disable iff (rst)
    sel_req |-> !rd_req);

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_req && !sel_ack) |=> sel_req);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  assert_temp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(temp));

  assert_reset_quiet_R12: assert property (@(posedge clk)
    rst |=> (!rd_req && !sel_req && !done && !err && temp == '0));
endmodule

bind thermo_avg thermo_avg_chk #(.MW(MATH_W)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .sel_req(sel_req),
  .sel_ack(sel_ack), .done(done), .err(err), .temp(temp)
);

// File: tb/thermo_avg_bench.sv
module thermo_avg_bench;
  localparam int SAMP_W  = 10;
  localparam int NSAMP   = 80;
  localparam int DISCARD = 2;
  localparam int DB      = 12;
  localparam int AB      = 150;
  localparam int MW      = 48;

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic rd_req;
  logic rsp_vld;
  logic [SAMP_W:0] rsp_word;
  logic sel_req;
  logic sel_ack;
  logic done;
  logic err;
  logic signed [MW-1:0] temp;

  always #10 clk = ~clk;

  thermo_avg #(
    .SAMP_W(SAMP_W), .NSAMP(NSAMP), .DISCARD(DISCARD),
    .DISC_BUDGET(DB), .ACC_BUDGET(AB), .MATH_W(MW)
  ) u_thermo_avg (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rsp_vld(rsp_vld),
    .rsp_word(rsp_word), .sel_req(sel_req), .sel_ack(sel_ack), .done(done),
    .err(err), .temp(temp)
  );

  int total = 0;
  int bad   = 0;

  // stimulus model
  int phase;
  int vcount [2];
  longint esum [2];
  int reads [2];
  int inv_pct;
  int vlimit;
  int lo [2];
  int hi [2];
  int ack_delay;
  int sel_wait;
  int sel_reads;
  int overlap;
  int ndone;
  int nreq;
  bit pend;
  int lat;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_temp(input longint s1, input longint s2);
    longint m1, m2, a, t1, t2, t3;
    m1 = (s1 * 1000) / NSAMP;
    m2 = (s2 * 1000) / NSAMP;
    if (m2 / 1000 == 0) m2 = 1000;
    a  = (m2 - m1) / (m2 / 1000);
    t1 = (-559 * a) / 1000;
    t2 = (t1 * a) / 1000;
    t3 = (1379 * a) / 1000;
    return t2 + t3 - 458;
  endfunction

  function automatic logic [SAMP_W:0] gen_word();
    int p;
    int s;
    bit v;
    p = phase;
    v = (vcount[p] < vlimit) && (($urandom % 100) >= inv_pct);
    reads[p]++;
    if (v) begin
      s = $urandom_range(hi[p], lo[p]);
      vcount[p]++;
      if (vcount[p] > DISCARD && vcount[p] <= DISCARD + NSAMP) esum[p] += s;
    end else begin
      s = $urandom % 1024;
    end
    return {v, s[SAMP_W-1:0]};
  endfunction

  // read responder
  initial begin
    rsp_vld  = 1'b0;
    rsp_word = '0;
    pend = 1'b0;
    lat  = 0;
    forever begin
      @(negedge clk);
      rsp_vld = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          rsp_vld  = 1'b1;
          rsp_word = gen_word();
          pend     = 1'b0;
        end else begin
          lat--;
        end
      end
      if (rd_req && !rst) begin
        if (pend) overlap++;
        pend = 1'b1;
        lat  = $urandom % 3;
      end
    end
  end

  // selector responder and monitors
  initial begin
    sel_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (sel_req && rd_req) sel_reads++;
      if (done) ndone++;
      if (rd_req) nreq++;
      if (sel_ack) begin
        sel_ack = 1'b0;
      end else if (sel_req) begin
        if (sel_wait == 0) begin
          sel_ack  = 1'b1;
          phase    = 1;
          sel_wait = ack_delay;
        end else begin
          sel_wait--;
        end
      end
    end
  end

  task automatic setup(input int ip, input int l1, input int h1, input int l2,
                       input int h2, input int vl, input int ad);
    phase = 0;
    vcount[0] = 0; vcount[1] = 0;
    esum[0] = 0; esum[1] = 0;
    reads[0] = 0; reads[1] = 0;
    inv_pct = ip; vlimit = vl;
    lo[0] = l1; hi[0] = h1; lo[1] = l2; hi[1] = h2;
    ack_delay = ad; sel_wait = ad;
    sel_reads = 0;
  endtask

  task automatic run(input bit extra_start, output bit got, output bit e,
                     output logic signed [MW-1:0] t);
    got = 1'b0; e = 1'b0; t = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 30000; i++) begin
      if (extra_start && i == 100) start = 1'b1;
      if (extra_start && i == 101) start = 1'b0;
      if (done) begin
        got = 1'b1; e = err; t = temp;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic good_case(input string tag, input int ip, input int l1, input int h1,
                           input int l2, input int h2, input int ad);
    bit got, e;
    logic signed [MW-1:0] t;
    longint ex;
    setup(ip, l1, h1, l2, h2, 1 << 30, ad);
    run(1'b0, got, e, t);
    ex = exp_temp(esum[0], esum[1]);
    chk(got && !e, {tag, " R4 run completes without error"}, longint'(e), 0);
    chk(t == ex, {tag, " R9 R1 R2 temperature"}, t, ex);
    chk(sel_reads == 0, {tag, " R7 no read while switching"}, sel_reads, 0);
  endtask

  initial begin
    bit got, e;
    logic signed [MW-1:0] t, prev;
    int d0, q0;
    void'($urandom(32'd4242));
    start = 1'b0;
    rst = 1'b1;
    overlap = 0; ndone = 0; nreq = 0;
    setup(0, 0, 0, 0, 0, 1 << 30, 0);
    repeat (5) @(negedge clk);
    // R12: reset state
    chk(!rd_req && !sel_req && !done && !err, "R12 outputs low in reset",
        {rd_req, sel_req, done, err}, 0);
    chk(temp == 0, "R12 temp zero in reset", temp, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // directed corners
    good_case("all-zero R8", 0, 0, 0, 0, 0, 0);
    chk(exp_temp(0, 0) == 362, "R8 floor reference", exp_temp(0, 0), 362);
    good_case("all-max", 0, 1023, 1023, 1023, 1023, 2);
    good_case("max-then-zero R8", 0, 1023, 1023, 0, 0, 1);
    good_case("tiny-m2 R8", 10, 0, 700, 0, 1, 4);
    good_case("invalid-mix R1", 20, 300, 900, 100, 600, 3);

    // constrained random
    for (int n = 0; n < 10; n++) begin
      int a1, a2, b1, b2;
      a1 = $urandom % 1024; a2 = a1 + ($urandom % (1024 - a1));
      b1 = $urandom % 1024; b2 = b1 + ($urandom % (1024 - b1));
      good_case("random R2", $urandom % 21, a1, a2, b1, b2, $urandom % 6);
    end

    // R6: one outstanding read, each request answered
    chk(overlap == 0, "R6 single outstanding read", overlap, 0);

    // R11: second start mid-run ignored
    setup(5, 200, 800, 400, 1000, 1 << 30, 2);
    d0 = ndone;
    run(1'b1, got, e, t);
    chk(t == exp_temp(esum[0], esum[1]), "R11 result unaffected by extra start",
        t, exp_temp(esum[0], esum[1]));
    q0 = nreq;
    repeat (800) @(negedge clk);
    chk(ndone - d0 == 1, "R11 exactly one done", ndone - d0, 1);
    chk(nreq == q0, "R11 no reads after done", nreq - q0, 0);
    prev = temp;

    // R3: warm-up budget exhausted
    setup(0, 0, 0, 0, 0, 0, 0);
    run(1'b0, got, e, t);
    chk(got && e, "R3 error flagged", longint'(e), 1);
    chk(reads[0] == DB + 1, "R3 read count at abort", reads[0], DB + 1);
    chk(t == prev, "R10 temp kept on error", t, prev);
    chk(reads[1] == 0, "R7 no phase two after abort", reads[1], 0);

    // R5: accumulation budget exhausted
    setup(0, 5, 5, 5, 5, DISCARD, 0);
    run(1'b0, got, e, t);
    chk(got && e, "R5 error flagged", longint'(e), 1);
    chk(reads[0] == DISCARD + AB + 1, "R5 read count at abort", reads[0], DISCARD + AB + 1);
    chk(t == prev, "R10 temp kept on error", t, prev);
    @(negedge clk);
    chk(!done && !err, "R10 done and err are pulses", {done, err}, 0);

    // recovery after an error
    good_case("after-error", 0, 512, 512, 600, 600, 0);
    chk(overlap == 0, "R6 single outstanding read at end", overlap, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule